// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Controller

The block sits between a processor core, the interrupt controller and the clock-control logic of a chip. Software programs an 8-bit wakeup control word over a simple write bus. The word holds an enable bit and a 4-bit priority threshold. Once enabled, the block watches a core-stopped status line. When the core reports that it has halted, the block raises an enter-low-power request toward the clock-control logic and holds it for the whole low-power interval.

While the chip is in low power, the block compares each incoming interrupt request against the threshold. The interrupt controller has already masked and prioritized the request. Only an unmasked request whose priority is strictly above the threshold ends the interval. The block then drops the enter request and raises an exit request, which tells the clock logic to turn the clocks back on. The exit request stays high until the core reports that it is running again. The block then returns to its idle run state.

No data stream passes through this block, so there is no valid/ready handshake. All pins are plain level-sensitive control and status signals, sampled on the rising clock edge. Nothing at the edge can back-pressure. A register write always completes in the cycle it is presented.

Top module: `lpw_ctrl_top`

## Requirements
- R1: The control word reads back on `cfg_rdata` in the cycle after a write. Bit 7 is the enable bit and bits 3:0 are the priority threshold. Bits 6:4 always read 0 and ignore written values. After reset the word reads 0x00.
- R2: While the enable bit is 0, a high `core_halted` leaves the block in the run state, with `lp_enter` and `lp_exit` both low, whatever interrupts arrive.
- R3: With the enable bit at 1 in the run state, a high `core_halted` at a clock edge makes `lp_enter` 1 after that edge. `lp_enter` stays 1 for as long as the block is in low power.
- R4: In low power, an interrupt with `irq_valid`=1, `irq_masked`=0 and `irq_prio` strictly greater than the threshold, sampled at an edge, gives `lp_exit`=1 and `lp_enter`=0 after that edge.
- R5: In low power, a request whose priority is equal to or below the threshold does not end low power, and neither does a masked request. `lp_enter` stays 1 and `lp_exit` stays 0.
- R6: Once raised, `lp_exit` stays 1 while `core_halted` is 1. After the first edge at which `core_halted` is 0, the block is back in run with both outputs 0.
- R7: `rst` is synchronous and active high. After an edge with `rst`=1, both outputs are 0, the block is in run and the control word is 0x00.
- R8: `lp_enter` and `lp_exit` are never 1 at the same time.
- R9: A drop of `core_halted` during low power, with no qualifying interrupt, does not leave low power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Write data for the control word |
| cfg_rdata | output | 8 | Current control word |
| core_halted | input | 1 | Core-stopped status from the processor |
| irq_valid | input | 1 | Interrupt request present |
| irq_masked | input | 1 | The present request is masked |
| irq_prio | input | 4 | Priority level of the present request |
| lp_enter | output | 1 | Request to the clock logic to enter low power |
| lp_exit | output | 1 | Request to the clock logic to restore clocks |

## Verification
The bench builds the block with its default 4-bit priority width. That makes only 16 threshold values and 16 request priorities, so it can sweep every threshold against every priority, in both masked and unmasked form. Each case includes a full enter, hold and exit sequence. The expected outcome is computed in the bench as "unmasked and priority above threshold". The sweep therefore covers the equal-priority boundary and the top threshold, which nothing can exceed. Disabled operation, a dropped halt during low power and reset from the low-power and exit states are each run on their own.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_LOWPWR  = 2'd1,
    ST_EXITING = 2'd2
  } lpw_state_e;

endpackage

// File: rtl/lpw_cfg_reg.sv
module lpw_cfg_reg #(
  parameter int REG_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              enable,
  output logic [PRIO_W-1:0] threshold
);
  localparam int EN_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << EN_BIT) | ((REG_W'(1) << PRIO_W) - REG_W'(1));

  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] wr_keep;

  assign wr_keep = wdata & WR_MASK;

  always_ff @(posedge clk) begin
    if (rst)     word_q <= '0;
    else if (we) word_q <= wr_keep;
  end

  assign rdata     = word_q;
  assign enable    = word_q[EN_BIT];
  assign threshold = word_q[PRIO_W-1:0];

  // R1
  cfg_write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata == ($past(wdata) & WR_MASK)));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));
endmodule

// File: rtl/lpw_prio_cmp.sv
module lpw_prio_cmp #(
  parameter int PRIO_W = 4
) (
  input  logic              irq_valid,
  input  logic              irq_masked,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] threshold,
  output logic              wake
);
  logic above;

  assign above = irq_prio > threshold;
  assign wake  = irq_valid && !irq_masked && above;

  // R5
  always_comb begin
    if (irq_masked) masked_no_wake_chk: assert (!wake);
  end
endmodule

// File: rtl/lpw_seq.sv
module lpw_seq
  import lpw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic core_halted,
  input  logic wake,
  output logic lp_enter,
  output logic lp_exit
);
  lpw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (enable && core_halted) state_d = ST_LOWPWR;
      ST_LOWPWR:  if (wake)                  state_d = ST_EXITING;
      ST_EXITING: if (!core_halted)          state_d = ST_RUN;
      default:                               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign lp_enter = (state_q == ST_LOWPWR);
  assign lp_exit  = (state_q == ST_EXITING);

  // R8
  enter_exit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lp_enter && lp_exit));

  // R2
  disabled_stays_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!lp_enter && !lp_exit && !enable) |=> !lp_enter);

  // R3
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!lp_enter && !lp_exit && enable && core_halted) |=> lp_enter);

  // R4
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_enter && wake) |=> (lp_exit && !lp_enter));

  // R5
  no_wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_enter && !wake) |=> lp_enter);

  // R6
  exit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_exit && core_halted) |=> lp_exit);

  // R6
  exit_release_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_exit && !core_halted) |=> (!lp_exit && !lp_enter));
endmodule

// File: rtl/lpw_ctrl_top.sv
module lpw_ctrl_top #(
  parameter int REG_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              core_halted,
  input  logic              irq_valid,
  input  logic              irq_masked,
  input  logic [PRIO_W-1:0] irq_prio,
  output logic              lp_enter,
  output logic              lp_exit
);
  logic              cfg_en;
  logic [PRIO_W-1:0] cfg_thr;
  logic              wake;

  lpw_cfg_reg #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .enable    (cfg_en),
    .threshold (cfg_thr)
  );

  lpw_prio_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .irq_valid  (irq_valid),
    .irq_masked (irq_masked),
    .irq_prio   (irq_prio),
    .threshold  (cfg_thr),
    .wake       (wake)
  );

  lpw_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .enable      (cfg_en),
    .core_halted (core_halted),
    .wake        (wake),
    .lp_enter    (lp_enter),
    .lp_exit     (lp_exit)
  );

  // R7
  reset_outputs_chk: assert property (@(posedge clk)
    rst |=> (!lp_enter && !lp_exit && cfg_rdata == '0));
endmodule

// File: tb/sim_lpw_ctrl_top.sv
module sim_lpw_ctrl_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       core_halted = 1'b0;
  logic       irq_valid = 1'b0;
  logic       irq_masked = 1'b0;
  logic [3:0] irq_prio = '0;
  logic       lp_enter, lp_exit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpw_ctrl_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .core_halted(core_halted), .irq_valid(irq_valid),
    .irq_masked(irq_masked), .irq_prio(irq_prio),
    .lp_enter(lp_enter), .lp_exit(lp_exit)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit e_en, input bit e_ex);
    chk(lp_enter == e_en && lp_exit == e_ex, req,
        {6'd0, lp_enter, lp_exit}, {6'd0, e_en, e_ex});
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    step();
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; core_halted = 1'b0; irq_valid = 1'b0;
    step();
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 01 expected 00");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R7: reset state
    chk(cfg_rdata == 8'h00, "R7 reset word", cfg_rdata, 8'h00);
    chk_out("R7 reset outputs", 0, 0);
    @(negedge clk); rst = 1'b0;

    // R1: reserved bits ignored
    wr(8'hFF);
    chk(cfg_rdata == 8'h8F, "R1 readback", cfg_rdata, 8'h8F);
    wr(8'h7A);
    chk(cfg_rdata == 8'h0A, "R1 readback", cfg_rdata, 8'h0A);

    // R2: disabled, halted core and high interrupts ignored
    wr(8'h70);
    @(negedge clk); core_halted = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(); chk_out("R2 disabled", 0, 0);
    end
    @(negedge clk); irq_valid = 1'b1; irq_prio = 4'hF; irq_masked = 1'b0;
    step(); chk_out("R2 disabled irq", 0, 0);
    @(negedge clk); irq_valid = 1'b0; core_halted = 1'b0;

    // Sweep every threshold / priority / mask
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 16; p++) begin
        for (int m = 0; m < 2; m++) begin
          bit exp_wake;
          exp_wake = (m == 0) && (p > t);
          wr(8'hF0 | 8'(t));
          chk(cfg_rdata == (8'h80 | 8'(t)), "R1 sweep readback", cfg_rdata,
              8'h80 | 8'(t));
          @(negedge clk); core_halted = 1'b1;
          step(); chk_out("R3 entry", 1, 0);
          step(); chk_out("R3 hold", 1, 0);
          @(negedge clk); irq_valid = 1'b1; irq_masked = m[0]; irq_prio = 4'(p);
          step();
          if (exp_wake) chk_out("R4 wake", 0, 1);
          else          chk_out("R5 no wake", 1, 0);
          @(negedge clk); irq_valid = 1'b0;
          if (exp_wake) begin
            step(); chk_out("R6 exit hold", 0, 1);
            @(negedge clk); core_halted = 1'b0;
            step(); chk_out("R6 release", 0, 0);
          end else begin
            step(); chk_out("R5 stays low power", 1, 0);
            do_reset();
            chk_out("R7 reset from low power", 0, 0);
            chk(cfg_rdata == 8'h00, "R7 reset word", cfg_rdata, 8'h00);
          end
        end
      end
    end

    // R9: core_halted drop in low power does not leave it
    wr(8'h85);
    @(negedge clk); core_halted = 1'b1;
    step(); chk_out("R3 entry", 1, 0);
    @(negedge clk); core_halted = 1'b0;
    step(); chk_out("R9 halt drop", 1, 0);
    step(); chk_out("R9 halt drop", 1, 0);
    @(negedge clk); irq_valid = 1'b1; irq_masked = 1'b0; irq_prio = 4'h6;
    step(); chk_out("R4 wake", 0, 1);
    @(negedge clk); irq_valid = 1'b0;
    step(); chk_out("R6 release", 0, 0);

    // R7: reset from exiting state
    @(negedge clk); core_halted = 1'b1;
    step(); chk_out("R3 entry", 1, 0);
    @(negedge clk); irq_valid = 1'b1; irq_prio = 4'hF;
    step(); chk_out("R4 wake", 0, 1);
    do_reset();
    chk_out("R7 reset from exit", 0, 0);
    step(); chk_out("R7 after reset", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule